// File: doc/BRIEF.md
# Cycle-Slip Lock Detector for a Frequency Synthesizer

This block judges whether a frequency-synthesizer loop is locked. It runs on the reference clock and receives a one-cycle strobe each time the phase detector sees a cycle slip. While the loop is unlocked, the block waits for a programmable run of reference clocks in which no slip occurs. When that run completes, it declares lock.

Once locked, the block ignores slips for a programmable blackout interval. After the blackout it counts slips inside repeating windows of the same length. When the count in a window reaches a programmable threshold, the block drops lock and starts acquisition again.

A force input holds the registered lock flag high, so that a power-amplifier interlock gated by the flag can be opened on demand. Dropping the synthesizer enable clears all of the block's state.

Top module: `pll_slip_lock_det`

## Requirements
- R1: After a synchronous reset, `lock_det` is 0.
- R2: While unlocked and enabled, `lock_det` rises at the clock edge that completes 2^(`lock_dly_sel`+4) consecutive enabled edges without a slip, and not earlier.
- R3: A slip seen during acquisition restarts the lock-delay count, so a full 2^(`lock_dly_sel`+4) slip-free edges must follow it.
- R4: For 2^(`blank_sel`+4) edges after lock is declared, slips are ignored and `lock_det` stays 1.
- R5: After the blackout, `lock_det` falls at the edge on which the slip count of the current window reaches 2^`slip_sel` (`slip_sel` 0,1,2,3 gives 1,2,4,8 slips). Fewer slips keep it at 1, and it never falls without a slip while enabled and not forced.
- R6: Slip counting uses back-to-back windows of 2^(`blank_sel`+4) edges. The count clears at each window rollover, and a slip on the rollover edge counts as the first slip of the new window.
- R7: With `synth_en` low, `lock_det` is 0 at the next edge (unless forced) and all counters clear, so re-enabling needs a full lock delay.
- R8: With `force_lock` high, `lock_det` is 1 from the next edge, regardless of slips or enable. Detection continues underneath, and the flag returns to the detector's verdict one edge after force is released.
- R9: `lock_det` is registered and changes only one edge after the input that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| synth_en | input | 1 | Synthesizer enable; low clears the detector |
| slip_pulse | input | 1 | One-cycle cycle-slip strobe |
| lock_dly_sel | input | 3 | Lock delay exponent: 2^(value+4) clocks |
| blank_sel | input | 3 | Blackout/window exponent: 2^(value+4) clocks |
| slip_sel | input | 2 | Unlock threshold: 2^value slips |
| force_lock | input | 1 | Holds lock_det high |
| lock_det | output | 1 | Registered lock flag |

## Verification
Every result of the block lands exactly one edge after the edge that samples its cause. Lock is due at the edge that completes the clean run, unlock at the edge carrying the threshold slip, and force or disable at the edge that follows them. The bench drives inputs and samples `lock_det` on falling edges, so each check reads the state after a known number of rising edges. Each timed check is paired with a check one edge earlier, which proves the change is neither early nor late. The window rollover test places slips on the edges on either side of the rollover, so that a count that fails to clear at the boundary is seen.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    typedef enum logic {
        LK_ACQUIRE = 1'b0,
        LK_LOCKED  = 1'b1
    } lock_state_e;

    typedef enum logic {
        PH_BLACKOUT = 1'b0,
        PH_MONITOR  = 1'b1
    } track_phase_e;

    // Terminal count of a span of 2^exp clocks.
    function automatic int unsigned span_last(input int unsigned exp);
        return (32'd1 << exp) - 32'd1;
    endfunction

    // Slip threshold for a selector value: 2^sel.
    function automatic int unsigned slip_limit(input int unsigned sel);
        return 32'd1 << sel;
    endfunction

endpackage

// File: rtl/lock_acq_timer.sv
module lock_acq_timer
    import pll_lock_pkg::*;
#(
    parameter int SEL_W    = 3,
    parameter int BASE_EXP = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             slip,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);
    localparam int CNT_W = (1 << SEL_W) - 1 + BASE_EXP;

    logic [CNT_W-1:0] clean_cnt;
    logic             at_end;

    always_comb begin
        at_end = (clean_cnt == CNT_W'(span_last(int'(sel) + BASE_EXP)));
        done   = run && !slip && at_end;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            clean_cnt <= '0;
        end else if (slip || at_end) begin
            clean_cnt <= '0;
        end else begin
            clean_cnt <= clean_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/slip_window_tracker.sv
module slip_window_tracker
    import pll_lock_pkg::*;
#(
    parameter int BLANK_W  = 3,
    parameter int SLIP_W   = 2,
    parameter int BASE_EXP = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               slip,
    input  logic [BLANK_W-1:0] blank_sel,
    input  logic [SLIP_W-1:0]  slip_sel,
    output logic               unlock_hit
);
    localparam int CNT_W = (1 << BLANK_W) - 1 + BASE_EXP;
    localparam int SC_W  = 1 << SLIP_W;

    track_phase_e     phase;
    logic [CNT_W-1:0] span_cnt;
    logic [SC_W-1:0]  slip_cnt;
    logic             rollover;
    logic [SC_W-1:0]  tally;

    always_comb begin
        rollover   = (span_cnt == CNT_W'(span_last(int'(blank_sel) + BASE_EXP)));
        // a slip on the rollover edge opens the new window's count
        tally      = (rollover ? '0 : slip_cnt) + SC_W'(slip);
        unlock_hit = run && (phase == PH_MONITOR) &&
                     (tally >= SC_W'(slip_limit(int'(slip_sel))));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase    <= PH_BLACKOUT;
            span_cnt <= '0;
            slip_cnt <= '0;
        end else begin
            span_cnt <= rollover ? '0 : span_cnt + 1'b1;
            if (phase == PH_BLACKOUT) begin
                slip_cnt <= '0;
                if (rollover) begin
                    phase <= PH_MONITOR;
                end
            end else begin
                slip_cnt <= tally;
            end
        end
    end
endmodule

// File: rtl/lock_state_ctrl.sv
module lock_state_ctrl
    import pll_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        force_hi,
    input  logic        acq_done,
    input  logic        unlock_hit,
    output lock_state_e state,
    output logic        lock_flag
);
    lock_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        if (!enable) begin
            state_nxt = LK_ACQUIRE;
        end else begin
            unique case (state)
                LK_ACQUIRE: if (acq_done)   state_nxt = LK_LOCKED;
                LK_LOCKED:  if (unlock_hit) state_nxt = LK_ACQUIRE;
                default:    state_nxt = LK_ACQUIRE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= LK_ACQUIRE;
            lock_flag <= 1'b0;
        end else begin
            state     <= state_nxt;
            lock_flag <= force_hi || (state_nxt == LK_LOCKED);
        end
    end
endmodule

// File: rtl/pll_slip_lock_det.sv
module pll_slip_lock_det
    import pll_lock_pkg::*;
#(
    parameter int LOCK_SEL_W  = 3,
    parameter int BLANK_SEL_W = 3,
    parameter int SLIP_SEL_W  = 2,
    parameter int BASE_EXP    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   synth_en,
    input  logic                   slip_pulse,
    input  logic [LOCK_SEL_W-1:0]  lock_dly_sel,
    input  logic [BLANK_SEL_W-1:0] blank_sel,
    input  logic [SLIP_SEL_W-1:0]  slip_sel,
    input  logic                   force_lock,
    output logic                   lock_det
);
    lock_state_e state;
    logic        acq_run;
    logic        trk_run;
    logic        acq_done;
    logic        unlock_hit;

    assign acq_run = synth_en && (state == LK_ACQUIRE);
    assign trk_run = synth_en && (state == LK_LOCKED);

    lock_acq_timer #(
        .SEL_W    (LOCK_SEL_W),
        .BASE_EXP (BASE_EXP)
    ) u_acq (
        .clk  (clk),
        .rst  (rst),
        .run  (acq_run),
        .slip (slip_pulse),
        .sel  (lock_dly_sel),
        .done (acq_done)
    );

    slip_window_tracker #(
        .BLANK_W  (BLANK_SEL_W),
        .SLIP_W   (SLIP_SEL_W),
        .BASE_EXP (BASE_EXP)
    ) u_trk (
        .clk        (clk),
        .rst        (rst),
        .run        (trk_run),
        .slip       (slip_pulse),
        .blank_sel  (blank_sel),
        .slip_sel   (slip_sel),
        .unlock_hit (unlock_hit)
    );

    lock_state_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .enable     (synth_en),
        .force_hi   (force_lock),
        .acq_done   (acq_done),
        .unlock_hit (unlock_hit),
        .state      (state),
        .lock_flag  (lock_det)
    );
endmodule

// File: rtl/pll_slip_lock_det_chk.sv
module pll_slip_lock_det_chk #(
    parameter int LOCK_SEL_W = 3,
    parameter int BASE_EXP   = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  synth_en,
    input logic                  slip_pulse,
    input logic [LOCK_SEL_W-1:0] lock_dly_sel,
    input logic                  force_lock,
    input logic                  lock_det
);
    logic [11:0] run_cnt;
    logic        force_q;
    logic [31:0] lock_len;

    always_comb lock_len = 32'd1 << (int'(lock_dly_sel) + BASE_EXP);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            force_q <= 1'b0;
        end else begin
            force_q <= force_lock;
            if (!synth_en || slip_pulse) begin
                run_cnt <= '0;
            end else if (run_cnt != '1) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // R8: force drives the flag high at the next edge
    assert_force_high_R8: assert property (@(posedge clk) disable iff (rst)
        force_lock |=> lock_det);

    // R7: disabled and not forced gives a low flag at the next edge
    assert_disable_low_R7: assert property (@(posedge clk) disable iff (rst)
        (!synth_en && !force_lock) |=> !lock_det);

    // R3: a slip while unlocked blocks lock at the next edge
    assert_slip_blocks_lock_R3: assert property (@(posedge clk) disable iff (rst)
        (slip_pulse && !force_lock && !lock_det) |=> !lock_det);

    // R2: no lock before the clean run reaches the lock delay
    assert_no_early_lock_R2: assert property (@(posedge clk) disable iff (rst)
        (!force_lock && !lock_det && synth_en && !slip_pulse &&
         ((32'(run_cnt) + 32'd1) < lock_len)) |=> !lock_det);

    // R5: no unlock without a slip while enabled and unforced
    assert_hold_without_slip_R5: assert property (@(posedge clk) disable iff (rst)
        (lock_det && !force_q && !force_lock && synth_en && !slip_pulse) |=> lock_det);
endmodule

bind pll_slip_lock_det pll_slip_lock_det_chk #(
    .LOCK_SEL_W (LOCK_SEL_W),
    .BASE_EXP   (BASE_EXP)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .synth_en     (synth_en),
    .slip_pulse   (slip_pulse),
    .lock_dly_sel (lock_dly_sel),
    .force_lock   (force_lock),
    .lock_det     (lock_det)
);

// File: tb/test_pll_slip_lock_det.sv
module test_pll_slip_lock_det;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       synth_en;
    logic       slip_pulse;
    logic [2:0] lock_dly_sel;
    logic [2:0] blank_sel;
    logic [1:0] slip_sel;
    logic       force_lock;
    logic       lock_det;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pll_slip_lock_det i_pll_slip_lock_det (
        .clk          (clk),
        .rst          (rst),
        .synth_en     (synth_en),
        .slip_pulse   (slip_pulse),
        .lock_dly_sel (lock_dly_sel),
        .blank_sel    (blank_sel),
        .slip_sel     (slip_sel),
        .force_lock   (force_lock),
        .lock_det     (lock_det)
    );

    // vector: {lock_dly_sel[2:0], blank_sel[2:0], slip_sel[1:0], slips[3:0]}
    localparam logic [11:0] VEC [6] = '{
        {3'd0, 3'd0, 2'd0, 4'd1},
        {3'd1, 3'd0, 2'd1, 4'd2},
        {3'd0, 3'd1, 2'd2, 4'd4},
        {3'd2, 3'd0, 2'd3, 4'd8},
        {3'd0, 3'd2, 2'd3, 4'd5},
        {3'd3, 3'd3, 2'd1, 4'd1}
    };

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: lock_det=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic reacquire(input string tag);
        synth_en   = 1'b0;
        slip_pulse = 1'b0;
        tick(1);
        synth_en = 1'b1;
        tick((1 << (lock_dly_sel + 4)) - 1);
        check(tag, lock_det, 1'b0);
        tick(1);
        check(tag, lock_det, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: expired, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; synth_en = 1'b0; slip_pulse = 1'b0; force_lock = 1'b0;
        lock_dly_sel = '0; blank_sel = '0; slip_sel = '0;
        tick(3);
        rst = 1'b0;
        check("R1 reset", lock_det, 1'b0);

        // table walk: lock timing (R2), then slips after blackout (R5)
        for (int v = 0; v < 6; v++) begin
            int w;
            int thr;
            int n;
            lock_dly_sel = VEC[v][11:9];
            blank_sel    = VEC[v][8:6];
            slip_sel     = VEC[v][5:4];
            n   = int'(VEC[v][3:0]);
            w   = 1 << (blank_sel + 4);
            thr = 1 << slip_sel;
            reacquire("R2 lock delay");
            tick(w);
            for (int i = 1; i <= n; i++) begin
                slip_pulse = 1'b1;
                tick(1);
                check("R5 slip threshold", lock_det, (i < thr) ? 1'b1 : 1'b0);
            end
            slip_pulse = 1'b0;
        end

        // R3: slip during acquisition restarts the count
        synth_en = 1'b0; tick(1);
        lock_dly_sel = 3'd0; blank_sel = 3'd0; slip_sel = 2'd0;
        synth_en = 1'b1;
        tick(10);
        slip_pulse = 1'b1; tick(1);
        check("R3 slip in acquisition", lock_det, 1'b0);
        slip_pulse = 1'b0;
        tick(15);
        check("R3 restart not early", lock_det, 1'b0);
        tick(1);
        check("R3 restart lock", lock_det, 1'b1);

        // R4: slips in blackout ignored, first monitored slip unlocks
        slip_pulse = 1'b1;
        tick(16);
        check("R4 blackout ignores slips", lock_det, 1'b1);
        tick(1);
        check("R4 first slip after blackout", lock_det, 1'b0);
        slip_pulse = 1'b0;

        // R6: slip on the rollover edge counts in the new window
        slip_sel = 2'd1;
        reacquire("R6 lock");
        tick(16);
        slip_pulse = 1'b1; tick(1);
        slip_pulse = 1'b0; tick(14);
        slip_pulse = 1'b1; tick(1);
        check("R6 rollover clears count", lock_det, 1'b1);
        tick(1);
        check("R6 rollover slip counted in new window", lock_det, 1'b0);
        slip_pulse = 1'b0;

        // R7 / R9: disable drops the flag one edge later and clears counters
        reacquire("R7 lock");
        synth_en = 1'b0;
        check("R9 no change before edge", lock_det, 1'b1);
        tick(1);
        check("R7 disable drops lock", lock_det, 1'b0);
        synth_en = 1'b1;
        tick(15);
        check("R7 full delay after re-enable", lock_det, 1'b0);
        tick(1);
        check("R7 relock", lock_det, 1'b1);

        // R8: force override
        synth_en = 1'b0; tick(1);
        force_lock = 1'b1;
        check("R9 force waits for edge", lock_det, 1'b0);
        tick(1);
        check("R8 force while disabled", lock_det, 1'b1);
        slip_pulse = 1'b1; tick(3);
        check("R8 force ignores slips", lock_det, 1'b1);
        slip_pulse = 1'b0;
        force_lock = 1'b0; tick(1);
        check("R8 release returns low", lock_det, 1'b0);

        // R8: detection continues under force
        slip_sel = 2'd0;
        force_lock = 1'b1; synth_en = 1'b1;
        tick(32);
        slip_pulse = 1'b1; tick(1);
        slip_pulse = 1'b0;
        check("R8 forced despite unlock", lock_det, 1'b1);
        force_lock = 1'b0; tick(1);
        check("R8 detector verdict after release", lock_det, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule